// File: doc/BRIEF.md
# Test Status Record Writer

This block sits beside a memory traffic engine and keeps the performance figures of one test run. It counts clock cycles, read and write request strobes and successful compare-and-exchange operations. It measures two overhead figures and gathers error bits into one error word. When the engine reports that the test has finished, the block packs every figure into one fixed 512-bit line. That line goes out as a single write request aimed at the status memory base address the host programmed. A completion can be normal or forced. Both produce the same record.

A test begins with a start pulse. From then until completion the block counts every cycle and every strobe, including those that arrive in the completion cycle itself. Every record carries a 15-bit sequence tag, so the host can tell a fresh status write from a stale one. An active-low test reset clears all counters and the tag, and it abandons a test in progress.

Top module: `stat_rec_writer`

## Requirements
- R1: After reset, `wr_valid_o` is low, and the first record written carries sequence tag 0.
- R2: A normal or forced completion seen while a test runs raises `wr_valid_o` for exactly one cycle, in the cycle after the completion, and bit 0 of the record is 1.
- R3: Bits 15:1 hold the sequence tag. The tag rises by one for each record and wraps from 32767 to 0.
- R4: Bits 127:64 hold the number of clock edges from the start edge up to and including the completion edge.
- R5: Bits 159:128 count read request strobes and bits 191:160 count write request strobes. Strobes in the completion cycle are counted.
- R6: Bits 223:192 hold the start overhead: the running cycles after the start edge and before the first read or write request.
- R7: Bits 255:224 hold the end overhead: the cycles from the latest request to the latest response that follows it. The value is 0 if no response followed. It is the cycles since start if no request has occurred yet.
- R8: Bits 63:32 hold the OR of every `err_set_i` value seen during the test.
- R9: Bits 31:16 count `cas_ok_i` pulses during the test.
- R10: Bits 511:256 hold `err_dump_i` as sampled in the completion cycle.
- R11: `wr_addr_o` equals the base address captured at completion with its low 6 bits forced to zero.
- R12: A forced completion yields the same record as a normal one. A normal and a forced completion in the same cycle yield a single record.
- R13: A completion while no test runs is ignored, and so is a start pulse during a running test. Neither produces a write, and the running counters are not cleared.
- R14: Holding `test_rst_n` low for one cycle aborts the test, suppresses any write, and clears the sequence tag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_rst_n | input | 1 | Synchronous active-low test reset |
| start_i | input | 1 | Test start pulse |
| done_i | input | 1 | Normal completion pulse |
| force_i | input | 1 | Forced completion pulse |
| rd_req_i | input | 1 | Read request issued |
| wr_req_i | input | 1 | Write request issued |
| rsp_i | input | 1 | Response received |
| cas_ok_i | input | 1 | Compare-and-exchange success |
| err_set_i | input | 32 | Error bits to accumulate |
| err_dump_i | input | 256 | Error dump captured at completion |
| stat_base_i | input | ADDR_W | Status memory base address |
| wr_valid_o | output | 1 | Status line write request |
| wr_addr_o | output | ADDR_W | Line-aligned write address |
| wr_data_o | output | 512 | Assembled status record |

## Verification
The riskiest overlap is a completion that lands in the same cycle as request, response, compare-and-exchange or error strobes. The bench drives completion together with such strobes and expects the record to include them. Start and completion also meet: the bench issues back-to-back two-cycle tests, and it sends a start while a test is running. A behavioural reference model advances on every edge, and each cycle's write strobe and each record field are compared against it.

// File: rtl/stat_rec_pkg.sv
package stat_rec_pkg;
  localparam int unsigned FLAG_W = 1;
  localparam int unsigned ID_W   = 15;
  localparam int unsigned CAS_W  = 16;
  localparam int unsigned ERR_W  = 32;
  localparam int unsigned CLK_W  = 64;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned DUMP_W = 256;
  localparam int unsigned REC_W  = FLAG_W + ID_W + CAS_W + ERR_W + CLK_W
                                   + 4 * CNT_W + DUMP_W;

  // Field order from MSB down fixes the record layout.
  typedef struct packed {
    logic [DUMP_W-1:0] dump;
    logic [CNT_W-1:0]  end_oh;
    logic [CNT_W-1:0]  start_oh;
    logic [CNT_W-1:0]  n_wr;
    logic [CNT_W-1:0]  n_rd;
    logic [CLK_W-1:0]  n_clk;
    logic [ERR_W-1:0]  err;
    logic [CAS_W-1:0]  cas;
    logic [ID_W-1:0]   id;
    logic [FLAG_W-1:0] done;
  } rec_t;

  typedef struct packed {
    logic [CNT_W-1:0] end_oh;
    logic [CNT_W-1:0] start_oh;
    logic [CNT_W-1:0] n_wr;
    logic [CNT_W-1:0] n_rd;
    logic [CLK_W-1:0] n_clk;
    logic [ERR_W-1:0] err;
    logic [CAS_W-1:0] cas;
  } perf_t;
endpackage

// File: rtl/stat_seq_ctl.sv
module stat_seq_ctl
  import stat_rec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_rst_n,
  input  logic            start_i,
  input  logic            done_i,
  input  logic            force_i,
  output logic            run_o,
  output logic            clr_o,
  output logic            fin_o,
  output logic [ID_W-1:0] id_o
);
  logic            run_q, run_d;
  logic [ID_W-1:0] id_q, id_d;

  assign clr_o = test_rst_n & ~run_q & start_i;
  assign fin_o = test_rst_n & run_q & (done_i | force_i);
  assign run_o = run_q;
  assign id_o  = id_q;

  always_comb begin
    run_d = run_q;
    id_d  = id_q;
    if (!test_rst_n) begin
      run_d = 1'b0;
      id_d  = '0;
    end else begin
      if (clr_o) run_d = 1'b1;
      if (fin_o) begin
        run_d = 1'b0;
        id_d  = id_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      id_q  <= '0;
    end else begin
      run_q <= run_d;
      id_q  <= id_d;
    end
  end
endmodule

// File: rtl/stat_counters.sv
module stat_counters
  import stat_rec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             rsp_i,
  input  logic             cas_i,
  input  logic [ERR_W-1:0] err_i,
  output perf_t            perf_o
);
  localparam int unsigned N_STRB = 2;

  logic                          req;
  logic [N_STRB-1:0]             strb;
  logic [N_STRB-1:0][CNT_W-1:0]  strb_cnt;
  logic                          wipe;

  assign req  = rd_i | wr_i;
  assign strb = {wr_i, rd_i};
  assign wipe = ~test_rst_n | clr_i;

  for (genvar g = 0; g < N_STRB; g++) begin : g_strb
    logic [CNT_W-1:0] q, d;
    always_comb begin
      d = q;
      if (wipe)                d = '0;
      else if (run_i && strb[g]) d = q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign strb_cnt[g] = d;
  end

  logic [CLK_W-1:0] clk_q, clk_d;
  logic [CNT_W-1:0] so_q, so_d, eo_q, eo_d, since_q, since_d;
  logic             seen_q, seen_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [CAS_W-1:0] cas_q, cas_d;

  always_comb begin
    clk_d   = clk_q;
    so_d    = so_q;
    eo_d    = eo_q;
    since_d = since_q;
    seen_d  = seen_q;
    err_d   = err_q;
    cas_d   = cas_q;
    if (wipe) begin
      clk_d   = '0;
      so_d    = '0;
      eo_d    = '0;
      since_d = '0;
      seen_d  = 1'b0;
      err_d   = '0;
      cas_d   = '0;
    end else if (run_i) begin
      clk_d = clk_q + 1'b1;
      if (!seen_q && !req) so_d = so_q + 1'b1;
      if (req) seen_d = 1'b1;
      if (req)        eo_d = '0;
      else if (rsp_i) eo_d = since_q + 1'b1;
      since_d = req ? '0 : since_q + 1'b1;
      err_d   = err_q | err_i;
      if (cas_i) cas_d = cas_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= '0;
      so_q    <= '0;
      eo_q    <= '0;
      since_q <= '0;
      seen_q  <= 1'b0;
      err_q   <= '0;
      cas_q   <= '0;
    end else begin
      clk_q   <= clk_d;
      so_q    <= so_d;
      eo_q    <= eo_d;
      since_q <= since_d;
      seen_q  <= seen_d;
      err_q   <= err_d;
      cas_q   <= cas_d;
    end
  end

  always_comb begin
    perf_o.end_oh   = eo_d;
    perf_o.start_oh = so_d;
    perf_o.n_wr     = strb_cnt[1];
    perf_o.n_rd     = strb_cnt[0];
    perf_o.n_clk    = clk_d;
    perf_o.err      = err_d;
    perf_o.cas      = cas_d;
  end
endmodule

// File: rtl/stat_rec_pack.sv
module stat_rec_pack
  import stat_rec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_rst_n,
  input  logic              fin_i,
  input  logic [ID_W-1:0]   id_i,
  input  perf_t             perf_i,
  input  logic [DUMP_W-1:0] dump_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REC_W-1:0]  data_o
);
  localparam int unsigned LSB = $clog2(LINE_BYTES);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  rec_t              rec_q, rec_d;

  always_comb begin
    valid_d = test_rst_n & fin_i;
    addr_d  = base_i;
    addr_d[LSB-1:0] = '0;
    rec_d.dump     = dump_i;
    rec_d.end_oh   = perf_i.end_oh;
    rec_d.start_oh = perf_i.start_oh;
    rec_d.n_wr     = perf_i.n_wr;
    rec_d.n_rd     = perf_i.n_rd;
    rec_d.n_clk    = perf_i.n_clk;
    rec_d.err      = perf_i.err;
    rec_d.cas      = perf_i.cas;
    rec_d.id       = id_i;
    rec_d.done     = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      rec_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (fin_i) begin
        addr_q <= addr_d;
        rec_q  <= rec_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = rec_q;
endmodule

// File: rtl/stat_rec_writer.sv
module stat_rec_writer
  import stat_rec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              force_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic              rsp_i,
  input  logic              cas_ok_i,
  input  logic [ERR_W-1:0]  err_set_i,
  input  logic [DUMP_W-1:0] err_dump_i,
  input  logic [ADDR_W-1:0] stat_base_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REC_W-1:0]  wr_data_o
);
  logic            run, clr, fin;
  logic [ID_W-1:0] id;
  perf_t           perf;

  stat_seq_ctl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_rst_n (test_rst_n),
    .start_i    (start_i),
    .done_i     (done_i),
    .force_i    (force_i),
    .run_o      (run),
    .clr_o      (clr),
    .fin_o      (fin),
    .id_o       (id)
  );

  stat_counters u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_rst_n (test_rst_n),
    .clr_i      (clr),
    .run_i      (run),
    .rd_i       (rd_req_i),
    .wr_i       (wr_req_i),
    .rsp_i      (rsp_i),
    .cas_i      (cas_ok_i),
    .err_i      (err_set_i),
    .perf_o     (perf)
  );

  stat_rec_pack #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_rst_n (test_rst_n),
    .fin_i      (fin),
    .id_i       (id),
    .perf_i     (perf),
    .dump_i     (err_dump_i),
    .base_i     (stat_base_i),
    .valid_o    (wr_valid_o),
    .addr_o     (wr_addr_o),
    .data_o     (wr_data_o)
  );
endmodule

// File: rtl/stat_rec_writer_chk.sv
module stat_rec_writer_chk
  import stat_rec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_rst_n,
  input logic              start_i,
  input logic              done_i,
  input logic              force_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic              rsp_i,
  input logic              cas_ok_i,
  input logic [ERR_W-1:0]  err_set_i,
  input logic [DUMP_W-1:0] err_dump_i,
  input logic [ADDR_W-1:0] stat_base_i,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [REC_W-1:0]  wr_data_o
);
  localparam int unsigned LSB = $clog2(LINE_BYTES);

  rec_t            rec;
  logic            obs_run;
  logic            ends;
  logic            have_prev;
  logic [ID_W-1:0] prev_id;

  assign rec  = wr_data_o;
  assign ends = test_rst_n && obs_run && (done_i || force_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs_run   <= 1'b0;
      have_prev <= 1'b0;
      prev_id   <= '0;
    end else begin
      if (!test_rst_n)                   obs_run <= 1'b0;
      else if (!obs_run && start_i)      obs_run <= 1'b1;
      else if (obs_run && (done_i || force_i)) obs_run <= 1'b0;
      if (!test_rst_n) begin
        have_prev <= 1'b0;
      end else if (wr_valid_o) begin
        have_prev <= 1'b1;
        prev_id   <= rec.id;
      end
    end
  end

  p_wr_needs_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(ends));
  p_end_gives_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ends |=> wr_valid_o);
  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> rec.done == 1'b1);
  p_one_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_addr_o[LSB-1:0] == '0);
  p_tag_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && have_prev) |-> rec.id == ID_W'(prev_id + 1'b1));
  p_treset_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(test_rst_n) |-> !wr_valid_o);
endmodule

bind stat_rec_writer stat_rec_writer_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (.*);

// File: tb/stat_rec_writer_tb_top.sv
module stat_rec_writer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_rst_n = 1'b1;
  logic         start_i = 0, done_i = 0, force_i = 0;
  logic         rd_req_i = 0, wr_req_i = 0, rsp_i = 0, cas_ok_i = 0;
  logic [31:0]  err_set_i = '0;
  logic [255:0] err_dump_i = '0;
  logic [63:0]  stat_base_i = '0;
  logic         wr_valid_o;
  logic [63:0]  wr_addr_o;
  logic [511:0] wr_data_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit live = 0;

  always #4 clk = ~clk;

  stat_rec_writer dut_i (.*);

  // Reference model
  bit           m_run;
  logic [63:0]  m_clk;
  logic [31:0]  m_rd, m_wr, m_so, m_eo, m_since, m_err;
  logic [15:0]  m_cas;
  logic [14:0]  m_id;
  bit           m_seen;
  bit           e_valid;
  logic [63:0]  e_addr;
  logic [511:0] e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_clk = 0; m_rd = 0; m_wr = 0; m_so = 0; m_eo = 0;
      m_since = 0; m_err = 0; m_cas = 0; m_id = 0; m_seen = 0; e_valid = 0;
    end else begin
      e_valid = 0;
      if (!test_rst_n) begin
        m_run = 0; m_id = 0;
      end else if (!m_run) begin
        if (start_i) begin
          m_run = 1; m_clk = 0; m_rd = 0; m_wr = 0; m_so = 0; m_eo = 0;
          m_since = 0; m_err = 0; m_cas = 0; m_seen = 0;
        end
      end else begin
        bit req;
        req = rd_req_i || wr_req_i;
        m_clk++;
        if (rd_req_i) m_rd++;
        if (wr_req_i) m_wr++;
        if (!m_seen && !req) m_so++;
        if (req) m_seen = 1;
        if (req) m_eo = 0;
        else if (rsp_i) m_eo = m_since + 1;
        if (req) m_since = 0; else m_since++;
        m_err |= err_set_i;
        if (cas_ok_i) m_cas++;
        if (done_i || force_i) begin
          e_valid = 1;
          e_addr = {stat_base_i[63:6], 6'b0};
          e_data = {err_dump_i, m_eo, m_so, m_wr, m_rd, m_clk, m_err, m_cas, m_id, 1'b1};
          m_id++;
          m_run = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2 R13 R14 write strobe", 256'(wr_valid_o), 256'(e_valid));
    if (e_valid && wr_valid_o) begin
      chk("R2 flag", 256'(wr_data_o[0]), 256'(1'b1));
      chk("R1 R3 tag", 256'(wr_data_o[15:1]), 256'(e_data[15:1]));
      chk("R9 cas", 256'(wr_data_o[31:16]), 256'(e_data[31:16]));
      chk("R8 err", 256'(wr_data_o[63:32]), 256'(e_data[63:32]));
      chk("R4 clocks", 256'(wr_data_o[127:64]), 256'(e_data[127:64]));
      chk("R5 reads", 256'(wr_data_o[159:128]), 256'(e_data[159:128]));
      chk("R5 writes", 256'(wr_data_o[191:160]), 256'(e_data[191:160]));
      chk("R6 start overhead", 256'(wr_data_o[223:192]), 256'(e_data[223:192]));
      chk("R7 end overhead", 256'(wr_data_o[255:224]), 256'(e_data[255:224]));
      chk("R10 dump", wr_data_o[511:256], e_data[511:256]);
      chk("R11 address", 256'(wr_addr_o), 256'(e_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit s, input bit d, input bit f, input bit rd,
                      input bit wr, input bit rs, input bit cs, input logic [31:0] e);
    start_i = s; done_i = d; force_i = f; rd_req_i = rd; wr_req_i = wr;
    rsp_i = rs; cas_ok_i = cs; err_set_i = e;
    @(negedge clk);
    start_i = 0; done_i = 0; force_i = 0; rd_req_i = 0; wr_req_i = 0;
    rsp_i = 0; cas_ok_i = 0; err_set_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset write strobe", 256'(wr_valid_o), 256'(1'b0));
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);

    // Normal test, first record tag 0, strobes in completion cycle
    stat_base_i = 64'h1234_5678_9abc_deff;
    err_dump_i  = rnd256();
    step(1,0,0,0,0,0,0,0);
    idle(3);
    step(0,0,0,1,0,0,0,32'h0000_0010);
    step(0,0,0,0,1,0,1,0);
    idle(2);
    step(0,0,0,0,0,1,0,32'h8000_0000);
    step(0,1,0,1,1,1,1,32'h0000_0002);
    idle(2);

    // Forced completion, response before any request
    stat_base_i = 64'hffff_0000_0000_007f;
    err_dump_i  = rnd256();
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,1,0,0,0,0);
    idle(1);
    step(0,0,0,0,0,1,1,0);
    idle(3);
    step(0,0,1,0,0,0,0,0);
    idle(2);

    // Normal and forced together, start overlapping a running test
    step(0,1,0,0,0,0,0,0);              // completion while idle
    idle(1);
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0);
    step(1,0,0,1,0,0,0,0);              // start while running
    step(0,1,1,0,0,0,0,32'h0000_0f00);
    step(1,0,0,0,0,0,0,0);              // back-to-back test
    step(0,1,0,0,0,0,0,0);
    idle(2);

    // Long pattern
    err_dump_i = rnd256();
    step(1,0,0,0,0,0,0,0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(0,0,0, r[0] & r[1], r[2] & r[3], r[4], r[5] & r[6], r[31:7] == 0 ? 32'h1 : 32'h0);
    end
    step(0,0,1,1,0,1,0,0);
    idle(2);

    // Test reset aborts and clears the tag
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,1,1,0,0,0);
    test_rst_n = 1'b0;
    step(0,1,0,0,0,0,0,0);
    test_rst_n = 1'b1;
    idle(2);
    step(1,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0);
    idle(2);

    // Tag wrap
    test_rst_n = 1'b0;
    step(0,0,0,0,0,0,0,0);
    test_rst_n = 1'b1;
    for (int i = 0; i < 32770; i++) begin
      step(1,0,0,0,0,0,0,0);
      step(0,1,0,0,0,0,0,0);
    end
    idle(3);

    live = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule